// File: doc/BRIEF.md
# Packed Dual-Entry Colour Palette

This block holds a 256-entry colour lookup table for a display pipeline. Software fills it through a 32-bit register window: each bus word carries two 16-bit palette entries side by side. Every entry has three 5-bit colour channels and one intensity flag. The pixel pipeline presents an 8-bit colour index each cycle. One cycle later the block returns a 24-bit RGB value, with each 5-bit channel widened to 8 bits by appending three zero bits.

Bus reads return the stored word unchanged, intensity flags included. The lookup path discards the intensity flag. The block decodes only its own window inside a 12-bit byte-offset space. Accesses outside that window leave the table untouched and read back as zero. Decoding the rest of the register space and scanning the screen belong to other blocks.

Top module: `duo_palette`

## Requirements
- R1: The window covers byte offsets BASE (0x200) through BASE+0x1FF. The word index is bus_addr[8:2] and bus_addr[1:0] is ignored, so there are 128 words.
- R2: A write strobe (bus_wr_en=1) inside the window stores all 32 bits of bus_wdata. A read strobe (bus_rd_en=1) inside the window returns that exact word on bus_rdata in the following cycle.
- R3: bus_rdata is zero in the cycle after a read strobe outside the window, and in the cycle after any cycle with no read strobe. A write outside the window changes no stored word.
- R4: Palette index 2n is bits [15:0] of word n, and index 2n+1 is bits [31:16] of word n.
- R5: Within a 16-bit entry, red is [4:0], green is [9:5] and blue is [14:10]. pix_rgb is {blue8, green8, red8}, with red8 at [7:0], green8 at [15:8] and blue8 at [23:16]. Each 8-bit channel equals its 5-bit field followed by 3'b000.
- R6: Entry bit 15 (the intensity flag) has no effect on pix_rgb.
- R7: pix_rgb reflects the pix_index presented one cycle earlier. A lookup presented in the same cycle as a write to its word returns the old contents. A lookup presented in the following cycle returns the new contents.
- R8: Synchronous active-high reset clears every stored word, bus_rdata and pix_rgb to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the bus access |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data (two packed entries) |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| pix_index | input | 8 | Palette index from the pixel pipeline |
| pix_rgb | output | 24 | Expanded colour for the previous cycle's index |

## Verification
The checker assumes that a read and a write are never strobed in the same cycle. It also assumes that a write followed by a read of the same offset arrives in back-to-back cycles, with no other write between them. The bench keeps to this by driving each bus access as a one-cycle strobe from a task, one at a time. The lookup checks assume pix_index is held steady while a write settles. The bench only changes the index on falling edges between accesses.

// File: rtl/duo_pal_pkg.sv
package duo_pal_pkg;
    localparam int CH_W   = 5;
    localparam int OUT_W  = 8;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int NCH    = 3;

    typedef struct packed {
        logic            inten;
        logic [CH_W-1:0] blue;
        logic [CH_W-1:0] green;
        logic [CH_W-1:0] red;
    } entry_t;

    typedef struct packed {
        logic [OUT_W-1:0] blue;
        logic [OUT_W-1:0] green;
        logic [OUT_W-1:0] red;
    } rgb_t;

    function automatic logic [OUT_W-1:0] widen(input logic [CH_W-1:0] ch);
        return {ch, {(OUT_W-CH_W){1'b0}}};
    endfunction
endpackage

// File: rtl/pal_window.sv
module pal_window #(
    parameter int          ADDR_W = 12,
    parameter logic [11:0] BASE   = 12'h200,
    parameter int          AW     = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [AW-1:0]     widx
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(BASE + (4 << AW));

    // BASE is aligned to the window size, so the word index is a plain slice
    assign hit  = (addr >= LO) && (addr < HI);
    assign widx = addr[AW+1:2];
endmodule

// File: rtl/pal_store.sv
module pal_store
    import duo_pal_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     ra_addr,
    output logic [WORD_W-1:0] ra_data,
    input  logic [AW-1:0]     rb_addr,
    output logic [WORD_W-1:0] rb_data
);
    localparam int WORDS = 1 << AW;

    logic [WORD_W-1:0] cells [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[w] <= '0;
            else if (we && (waddr == AW'(w)))
                cells[w] <= wdata;
        end
    end

    assign ra_data = cells[ra_addr];
    assign rb_data = cells[rb_addr];
endmodule

// File: rtl/pal_expand.sv
module pal_expand
    import duo_pal_pkg::*;
(
    input  entry_t ent,
    output rgb_t   rgb
);
    logic [CH_W-1:0]  ch_in  [NCH];
    logic [OUT_W-1:0] ch_out [NCH];

    assign ch_in[0] = ent.red;
    assign ch_in[1] = ent.green;
    assign ch_in[2] = ent.blue;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ch_out[c] = widen(ch_in[c]);
    end

    // the intensity flag is not routed to any channel
    assign rgb = '{blue: ch_out[2], green: ch_out[1], red: ch_out[0]};
endmodule

// File: rtl/duo_palette.sv
module duo_palette
    import duo_pal_pkg::*;
#(
    parameter int          ADDR_W = 12,
    parameter logic [11:0] BASE   = 12'h200,
    parameter int          IDX_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr_en,
    input  logic [WORD_W-1:0]    bus_wdata,
    input  logic                 bus_rd_en,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [IDX_W-1:0]     pix_index,
    output logic [3*OUT_W-1:0]   pix_rgb
);
    localparam int AW = IDX_W - 1;

    logic              hit;
    logic [AW-1:0]     widx;
    logic [WORD_W-1:0] bus_word;
    logic [WORD_W-1:0] pix_word;
    entry_t            pix_ent;
    rgb_t              rgb_next;
    rgb_t              rgb_q;

    pal_window #(.ADDR_W(ADDR_W), .BASE(BASE), .AW(AW)) u_win (
        .addr (bus_addr),
        .hit  (hit),
        .widx (widx)
    );

    pal_store #(.AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (bus_wr_en && hit),
        .waddr   (widx),
        .wdata   (bus_wdata),
        .ra_addr (widx),
        .ra_data (bus_word),
        .rb_addr (pix_index[IDX_W-1:1]),
        .rb_data (pix_word)
    );

    // even index takes the low half, odd index the high half
    assign pix_ent = pix_index[0] ? entry_t'(pix_word[WORD_W-1:HALF_W])
                                  : entry_t'(pix_word[HALF_W-1:0]);

    pal_expand u_exp (
        .ent (pix_ent),
        .rgb (rgb_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb_q     <= '0;
            bus_rdata <= '0;
        end else begin
            rgb_q     <= rgb_next;
            bus_rdata <= (bus_rd_en && hit) ? bus_word : '0;
        end
    end

    assign pix_rgb = rgb_q;
endmodule

// File: rtl/duo_palette_chk.sv
module duo_palette_chk #(
    parameter int          ADDR_W = 12,
    parameter logic [11:0] BASE   = 12'h200,
    parameter int          IDX_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd_en,
    input logic [31:0]       bus_rdata,
    input logic [IDX_W-1:0]  pix_index,
    input logic [23:0]       pix_rgb
);
    localparam int AW = IDX_W - 1;
    localparam int LO = int'(BASE);
    localparam int HI = LO + (4 << AW);

    logic in_win;
    assign in_win = (int'(bus_addr) >= LO) && (int'(bus_addr) < HI);

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0 && pix_rgb == '0));

    // R3
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_en || !in_win) |=> (bus_rdata == '0));

    // R2
    write_read_back_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && !bus_wr_en && in_win && $past(bus_wr_en) && $past(in_win)
         && bus_addr == $past(bus_addr))
        |=> (bus_rdata == $past(bus_wdata, 2)));

    // R7
    lookup_low_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_wr_en) && $past(in_win) && !pix_index[0]
         && pix_index[IDX_W-1:1] == $past(bus_addr[AW+1:2]))
        |=> (pix_rgb[7:0] == {$past(bus_wdata[4:0], 2), 3'b000}));

    // R7
    lookup_high_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_wr_en) && $past(in_win) && pix_index[0]
         && pix_index[IDX_W-1:1] == $past(bus_addr[AW+1:2]))
        |=> (pix_rgb[23:16] == {$past(bus_wdata[30:26], 2), 3'b000}));
endmodule

bind duo_palette duo_palette_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_duo_palette.sv
module test_duo_palette;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_index = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model [128];

    duo_palette i_duo_palette (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input int n, input int seed);
        logic [31:0] v;
        v = 32'(n + seed) * 32'h9E37_79B9;
        return v ^ (32'(n) << 9) ^ 32'(seed);
    endfunction

    function automatic logic [23:0] exp_rgb(input logic [31:0] w, input logic odd);
        logic [15:0] h;
        h = odd ? w[31:16] : w[15:0];
        return {h[14:10], 3'b000, h[9:5], 3'b000, h[4:0], 3'b000};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic lookup(input logic [7:0] i, output logic [23:0] c);
        @(negedge clk);
        pix_index = i;
        @(negedge clk);
        c = pix_rgb;
    endtask

    task automatic sweep_all(input string req);
        logic [31:0] d;
        logic [23:0] c;
        for (int w = 0; w < 128; w++) begin
            bus_read(12'h200 + 12'(w*4), d);
            check({req, " readback"}, d, model[w]);
        end
        for (int i = 0; i < 256; i++) begin
            lookup(8'(i), c);
            check({req, " lookup"}, {8'h0, c}, {8'h0, exp_rgb(model[i/2], i[0])});
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [23:0] c;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 rdata", bus_rdata, 0);
        check("R8 rgb", {8'h0, pix_rgb}, 0);
        rst = 1'b0;
        for (int w = 0; w < 128; w++) model[w] = '0;
        bus_read(12'h2A4, d);
        check("R8 word", d, 0);
        lookup(8'd77, c);
        check("R8 lookup", {8'h0, c}, 0);

        // R1 R2 R4 R5: fill every word, sweep read-back and all indices
        for (int w = 0; w < 128; w++) begin
            model[w] = pat(w, 11);
            bus_write(12'h200 + 12'(w*4) + 12'(w % 4), model[w]);
        end
        sweep_all("R1 R2 R4 R5");

        // R6: flip only the intensity bits, colours must not move
        for (int w = 0; w < 128; w++) begin
            model[w] = model[w] ^ 32'h8000_8000;
            bus_write(12'h200 + 12'(w*4), model[w]);
        end
        sweep_all("R6");

        // R5: per-channel extremes
        model[5] = 32'h7C1F_03E0;
        bus_write(12'h214, model[5]);
        lookup(8'd10, c); check("R5 green only", {8'h0, c}, 32'h0000_F800);
        lookup(8'd11, c); check("R5 red+blue", {8'h0, c}, 32'h00F8_00F8);

        // R3: outside-window writes change nothing, reads give zero
        bus_write(12'h1FC, 32'hDEAD_BEEF);
        bus_write(12'h400, 32'hCAFE_F00D);
        bus_write(12'h000, 32'h1234_5678);
        bus_write(12'hFFC, 32'h5555_AAAA);
        bus_read(12'h1FC, d); check("R3 below", d, 0);
        bus_read(12'h400, d); check("R3 above", d, 0);
        sweep_all("R3 unchanged");
        @(negedge clk);
        check("R3 no strobe", bus_rdata, 0);

        // R7: same-cycle lookup sees old data, next cycle sees new
        @(negedge clk);
        pix_index = 8'd41;
        bus_addr = 12'h250; bus_wdata = 32'h0421_7FFF; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        check("R7 old", {8'h0, pix_rgb}, {8'h0, exp_rgb(model[20], 1'b1)});
        @(negedge clk);
        model[20] = 32'h0421_7FFF;
        check("R7 new", {8'h0, pix_rgb}, {8'h0, exp_rgb(model[20], 1'b1)});

        // R8: reset in mid-run clears the table
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int w = 0; w < 128; w++) model[w] = '0;
        sweep_all("R8 after reset");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule